// File: doc/BRIEF.md
# Windowed Watchdog with Reset-Latched Configuration

This block is a watchdog counter that advances on a slow tick enable. An 8-bit option byte is captured while reset is held, and the block keeps that setting until the next reset. The option byte controls five things:

- whether the counter runs at all;
- the overflow period;
- the size of a refresh window at the end of each period;
- whether an early-warning interrupt is raised at three quarters of the period;
- whether counting continues while the system sleeps.

Software keeps the watchdog alive by sending refresh transfers on a valid/ready channel. Each transfer carries a key byte. A refresh is accepted only when two conditions hold: the key matches, and the count has entered the open window. Any other refresh asks for a system reset, as does a count that reaches the end of its period. Both outputs are registered single-cycle pulses, so each appears one clock after the edge that caused it.

The refresh channel never applies back-pressure. `kick_ready` is low while reset is held and during the first clock after reset is released. From the second clock after release onward it stays high. A transfer takes place in every cycle where `kick_valid` and `kick_ready` are both high. A beat presented while ready is low is dropped.

Top module: `wdt_guard`

## Requirements
- R1: While reset is held and in the first cycle after it, `early_irq`, `reset_req` and `kick_ready` are low. The count starts from zero.
- R2: The option byte is sampled only while reset is high. Changing it after release has no effect. Its bits are: bit 7 interrupt enable, bits 6:5 window code, bit 4 run enable, bits 3:1 period code, bit 0 sleep-run.
- R3: Period codes 000, 001, 010, 011 and 100 select 64, 128, 256, 512 and 2048 ticks. When the count reaches the period, `reset_req` pulses for one cycle and the count restarts from zero.
- R4: When bit 7 is set, `early_irq` pulses once when the count reaches 3/4 of the period. It fires at most once per period. When bit 7 is clear, it never fires.
- R5: Window codes 01, 10 and 11 open the window for the last 50%, 75% or 100% of the period. A refresh taken while the count is below period minus the open fraction raises `reset_req`.
- R6: A refresh whose data byte is not 8'hAC raises `reset_req`, whatever the window state.
- R7: A legal refresh raises no pulse, clears the count and re-arms the interrupt. A refresh on the same cycle as a tick takes priority over the tick.
- R8: When bit 4 is 0, the counter stays stopped, refreshes are ignored, and no pulse is ever raised.
- R9: With bit 0 clear, the count freezes while `sleep_i` is high, and the window is fully open whatever its code. With bit 0 set, sleep has no effect.
- R10: Window code 00 and period codes 101 to 111 are prohibited. With the counter enabled, a prohibited setting raises one `reset_req` on the first tick. After that the counter stays stopped and refreshes are ignored.
- R11: The count advances only in cycles where `tick_en` is high.
- R12: Any beat on which both `kick_valid` and `kick_ready` are high is consumed as a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; option byte captured while high |
| tick_en | input | 1 | Slow-clock enable, one cycle per watchdog tick |
| opt_byte | input | 8 | Option byte, sampled during reset |
| sleep_i | input | 1 | High while the system is in a low-power mode |
| kick_valid | input | 1 | Refresh beat present |
| kick_ready | output | 1 | Refresh channel able to take a beat |
| kick_data | input | 8 | Refresh key byte |
| early_irq | output | 1 | One-cycle interval-interrupt pulse |
| reset_req | output | 1 | One-cycle system-reset request pulse |

## Verification
The assertions assume three things about the inputs. First, the option byte is stable for at least one clock while reset is held. Second, refresh beats are single-cycle pulses. Third, `sleep_i` and `tick_en` change only between clock edges. The stimulus meets these assumptions:

- every input is driven on the falling edge;
- every refresh is a one-cycle beat;
- reset is held for several clocks with the option byte already settled.

The expected pulse times are derived from the programmed period and from the cycles at which refreshes and sleep intervals are placed. These include refreshes exactly at the window edge and one tick short of it.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int BASE_EXP = 6;
  localparam int TOP_EXP  = 11;
  localparam int TOP_CODE = 4;
  localparam int CNT_W    = TOP_EXP + 1;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic       irq_en;
    logic [1:0] win;
    logic       run_en;
    logic [2:0] ovf;
    logic       sleep_run;
  } cfg_t;

  // period exponent for a period code, 0 marks a prohibited code
  function automatic logic [3:0] ovf_exp(input logic [2:0] code);
    if (code < 3'(TOP_CODE)) return 4'(BASE_EXP) + 4'(code);
    if (code == 3'(TOP_CODE)) return 4'(TOP_EXP);
    return 4'd0;
  endfunction
endpackage

// File: rtl/wdt_guard_cfg.sv
module wdt_guard_cfg
  import wdt_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] opt_byte,
  output cfg_t       cfg,
  output cnt_t       limit,
  output cnt_t       thr,
  output cnt_t       win_start,
  output logic       bad
);
  logic [3:0] ex;

  // option byte is captured only while reset is asserted
  always_ff @(posedge clk) begin
    if (rst) cfg <= cfg_t'(opt_byte);
  end

  assign ex = ovf_exp(cfg.ovf);

  always_comb begin
    limit = (ex == 4'd0) ? '0 : (cnt_t'(1) << ex);
    thr   = (limit >> 1) + (limit >> 2);
    bad   = (ex == 4'd0) || (cfg.win == 2'b00);
    if (!cfg.sleep_run) begin
      win_start = '0;
    end else begin
      case (cfg.win)
        2'b01:   win_start = limit >> 1;
        2'b10:   win_start = limit >> 2;
        default: win_start = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_guard_cnt.sv
module wdt_guard_cnt
  import wdt_guard_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic clr,
  input  cnt_t limit,
  input  cnt_t thr,
  output cnt_t cnt,
  output logic ovf_hit,
  output logic thr_hit
);
  cnt_t nxt;

  assign nxt     = cnt + cnt_t'(1);
  assign ovf_hit = adv && (nxt == limit);
  assign thr_hit = adv && (nxt == thr);

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (ovf_hit) cnt <= '0;
    else if (adv)     cnt <= nxt;
  end

  // R3: reaching the period wraps the count to zero
  p_ovf_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_hit |=> (cnt == '0));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter logic [7:0] KEY = 8'hAC
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic [7:0] opt_byte,
  input  logic       sleep_i,
  input  logic       kick_valid,
  output logic       kick_ready,
  input  logic [7:0] kick_data,
  output logic       early_irq,
  output logic       reset_req
);
  cfg_t cfg;
  cnt_t limit, thr, win_start, cnt;
  logic bad, ovf_hit, thr_hit;
  logic active, adv, take, kick_eval, kick_bad, bad_fire;
  logic armed, bad_done, irq_d, req_d;

  wdt_guard_cfg u_cfg (
    .clk(clk), .rst(rst), .opt_byte(opt_byte), .cfg(cfg),
    .limit(limit), .thr(thr), .win_start(win_start), .bad(bad)
  );

  assign active    = cfg.run_en && !bad;
  assign take      = kick_valid && kick_ready;
  assign kick_eval = take && active;
  assign kick_bad  = kick_eval && ((kick_data != KEY) || (cnt < win_start));
  // a refresh in the same cycle as a tick wins over the tick
  assign adv       = active && tick_en && (!sleep_i || cfg.sleep_run) && !kick_eval;
  assign bad_fire  = cfg.run_en && bad && !bad_done && tick_en;

  wdt_guard_cnt u_cnt (
    .clk(clk), .rst(rst), .adv(adv), .clr(kick_eval),
    .limit(limit), .thr(thr), .cnt(cnt),
    .ovf_hit(ovf_hit), .thr_hit(thr_hit)
  );

  assign irq_d = cfg.irq_en && armed && thr_hit;
  assign req_d = kick_bad || ovf_hit || bad_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b1;
      bad_done   <= 1'b0;
      kick_ready <= 1'b0;
      early_irq  <= 1'b0;
      reset_req  <= 1'b0;
    end else begin
      kick_ready <= 1'b1;
      early_irq  <= irq_d;
      reset_req  <= req_d;
      if (bad_fire) bad_done <= 1'b1;
      if (kick_eval || ovf_hit) armed <= 1'b1;
      else if (irq_d)           armed <= 1'b0;
    end
  end

  // R4: interrupt never fires on two cycles in a row
  p_irq_single_r4: assert property (@(posedge clk) disable iff (rst)
    early_irq |=> !early_irq);

  // R5: correct key while window closed requests reset
  p_closed_kick_r5: assert property (@(posedge clk) disable iff (rst)
    (take && active && kick_data == KEY && cnt < win_start) |=> reset_req);

  // R6: wrong key requests reset
  p_bad_key_r6: assert property (@(posedge clk) disable iff (rst)
    (take && active && kick_data != KEY) |=> reset_req);

  // R8: a stopped watchdog stays silent
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg.run_en |-> (!reset_req && !early_irq));

  // R9: sleep freezes the count when sleep-run is off
  p_sleep_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && !cfg.sleep_run && !kick_valid) |=> $stable(cnt));

  // R10: a prohibited setting fires only once
  p_bad_cfg_once_r10: assert property (@(posedge clk) disable iff (rst)
    (bad && bad_done) |=> !reset_req);

  // R11: no tick, no refresh, no movement
  p_tick_gate_r11: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !kick_valid) |=> $stable(cnt));
endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
  timeunit 1ns;
  timeprecision 100ps;

  typedef struct {
    int    at;
    bit    is_rst;
    string req;
  } evt_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_all = 1'b1;
  logic       tick_en;
  logic [7:0] opt_byte = 8'h00;
  logic       sleep_i = 1'b0;
  logic       kick_valid = 1'b0;
  logic [7:0] kick_data = 8'h00;
  logic       kick_ready, early_irq, reset_req;

  int   cyc = 0;
  int   t0 = 0;
  int   checks = 0;
  int   errors = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;
  evt_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tick_en = tick_all | cyc[0];

  wdt_guard uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .opt_byte(opt_byte),
    .sleep_i(sleep_i), .kick_valid(kick_valid), .kick_ready(kick_ready),
    .kick_data(kick_data), .early_irq(early_irq), .reset_req(reset_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_evt(input int n, input bit is_rst, input string req);
    evt_t e;
    e.at = t0 + n;
    e.is_rst = is_rst;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic pop_cmp(input bit is_rst);
    evt_t e;
    checks++;
    if (sb.size() == 0) begin
      errors++;
      $display("FAIL unexpected %s at cycle %0d: actual pulse expected none",
               is_rst ? "reset_req" : "early_irq", cyc - t0);
    end else begin
      e = sb.pop_front();
      if (e.at != cyc || e.is_rst != is_rst) begin
        errors++;
        $display("FAIL %s: actual kind %0d at %0d expected kind %0d at %0d",
                 e.req, is_rst, cyc - t0, e.is_rst, e.at - t0);
      end
    end
  endtask

  // monitor: every output pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (early_irq) pop_cmp(1'b0);
      if (reset_req) pop_cmp(1'b1);
    end
  end

  task automatic drain(input string req);
    chk(sb.size() == 0, req, sb.size(), 0);
    sb.delete();
  endtask

  task automatic start(input logic [7:0] cfg);
    @(negedge clk);
    mon_on = 1'b0;
    rst = 1'b1;
    opt_byte = cfg;
    repeat (3) @(negedge clk);
    if (cyc % 2 != 0) @(negedge clk);
    rst = 1'b0;
    t0 = cyc;
    mon_on = 1'b1;
  endtask

  task automatic wait_at(input int n);
    while (cyc < t0 + n) @(negedge clk);
  endtask

  task automatic kick(input logic [7:0] d);
    kick_valid = 1'b1;
    kick_data = d;
    @(negedge clk);
    kick_valid = 1'b0;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    start(8'hF1);
    chk(kick_ready == 1'b0, "R1 ready at release", kick_ready, 0);
    chk(early_irq == 1'b0 && reset_req == 1'b0, "R1 pulses at release",
        {early_irq, reset_req}, 0);
    @(negedge clk);
    chk(kick_ready == 1'b1, "R12 ready after reset", kick_ready, 1);

    // R2/R4/R7/R3: period 64, full window, interrupt on; option changed after release
    opt_byte = 8'h00;
    expect_evt(48, 1'b0, "R4 irq at 3/4");
    wait_at(50);
    kick(8'hAC);
    expect_evt(99, 1'b0, "R7 irq re-armed after refresh");
    expect_evt(115, 1'b1, "R3 overflow after refresh clear");
    expect_evt(163, 1'b0, "R2 irq in next period");
    wait_at(170);
    drain("R2 scoreboard drained");

    // R5/R6: 50% window, period 128, no interrupt
    start(8'h33);
    wait_at(10);
    expect_evt(11, 1'b1, "R5 refresh with window closed");
    kick(8'hAC);
    wait_at(81);
    kick(8'hAC);
    wait_at(146);
    kick(8'hAC);
    wait_at(210);
    expect_evt(211, 1'b1, "R5 refresh one tick before window edge");
    kick(8'hAC);
    wait_at(311);
    expect_evt(312, 1'b1, "R6 wrong key in open window");
    kick(8'h55);
    expect_evt(440, 1'b1, "R3 overflow after bad refresh clear");
    wait_at(445);
    drain("R5 scoreboard drained");

    // R5: 75% window, period 64
    start(8'h51);
    wait_at(15);
    expect_evt(16, 1'b1, "R5 75% window closed");
    kick(8'hAC);
    wait_at(32);
    kick(8'hAC);
    expect_evt(97, 1'b1, "R5 75% window legal edge then overflow");
    wait_at(100);
    drain("R5 75% drained");

    // R9: sleep-run off, window forced open, count freezes in sleep
    start(8'h30);
    wait_at(5);
    kick(8'hAC);
    wait_at(10);
    sleep_i = 1'b1;
    wait_at(30);
    sleep_i = 1'b0;
    expect_evt(90, 1'b1, "R9 overflow delayed by sleep");
    wait_at(95);
    drain("R9 frozen drained");

    // R9: sleep-run on, sleep ignored; R4 interrupt off
    start(8'h71);
    sleep_i = 1'b1;
    wait_at(20);
    sleep_i = 1'b0;
    expect_evt(64, 1'b1, "R9 sleep ignored when sleep-run set");
    wait_at(70);
    drain("R4 no irq when disabled");

    // R8: counter disabled, refresh ignored
    start(8'h61);
    wait_at(100);
    kick(8'h55);
    wait_at(200);
    drain("R8 disabled stays silent");

    // R3/R4: remaining period codes
    for (int code = 1; code <= 4; code++) begin
      int lim;
      lim = (code == 4) ? 2048 : (1 << (6 + code));
      start({1'b1, 2'b11, 1'b1, 3'(code), 1'b1});
      expect_evt(lim - lim / 4, 1'b0, "R4 irq for period code");
      expect_evt(lim, 1'b1, "R3 overflow for period code");
      wait_at(lim + 2);
      drain("R3 period code drained");
    end

    // R10: prohibited codes
    start(8'h7B);
    expect_evt(1, 1'b1, "R10 bad period code 101");
    wait_at(100);
    kick(8'h55);
    wait_at(300);
    drain("R10 bad period stops");
    start(8'h7F);
    expect_evt(1, 1'b1, "R10 bad period code 111");
    wait_at(150);
    drain("R10 bad 111 drained");
    start(8'h11);
    expect_evt(1, 1'b1, "R10 bad window code 00");
    wait_at(150);
    drain("R10 bad window drained");

    // R11: tick on alternate cycles doubles the timing
    tick_all = 1'b0;
    start(8'hF1);
    expect_evt(96, 1'b0, "R11 irq with half-rate tick");
    expect_evt(128, 1'b1, "R11 overflow with half-rate tick");
    wait_at(132);
    drain("R11 drained");
    tick_all = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule